// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data Unit

This block is the arithmetic heart of an audio processing datapath. It takes two signed 24-bit fractional operands and forms their product. In one clock it loads, adds or subtracts that product into one of two 56-bit accumulators, or loads its negation. Each accumulator has 8 guard bits above a 24-bit upper word and a 24-bit lower word. The guard bits let long filter sums grow past unity without wrapping. An optional convergent rounding step settles the result to the upper word.

After each operation four registered condition flags describe the result: negative, zero, overflow and extension-in-use. A separate read port always presents one accumulator as a 24-bit word. It can first scale the value up or down by one bit, and it saturates to the nearest full-scale value when the result will not fit. A fifth flag reports when that limit was applied.

The block is purely a datapath. It has no state machine: each valid operation finishes in the cycle it is presented. An upstream sequencer supplies opcodes and operands, and reads results through the read port.

Top module: `fracmac_unit`

## Requirements
- R1: The product is the signed 48-bit product of `op_a` and `op_b`, sign-extended to 56 bits and shifted left by one. For -1.0 times -1.0 (0x800000 by 0x800000) this gives +1.0, which is 0x00_800000_000000, with no wrap.
- R2: `opcode` selects the operation. 2'b00 loads the product, 2'b01 adds it to the destination accumulator, 2'b10 subtracts it from the destination accumulator, and 2'b11 loads the negated product.
- R3: An operation presented with `in_valid` high is visible in the accumulator and the flags right after the next rising clock edge. While `in_valid` is low, no accumulator changes.
- R4: `acc_sel` (0 or 1) names the destination accumulator. The other accumulator keeps its value.
- R5: When `round_en` is high, the 56-bit result gets half of an upper-word LSB (2^23) added and its lower 24 bits cleared. If the discarded lower word was exactly 0x800000, bit 24 of the result is also cleared, so ties go to an even upper word.
- R6: After each operation, `flag_n` equals bit 55 of the new accumulator and `flag_z` is set when all 56 bits are zero. `flag_e` is set when bits 55 down to 47 are not all equal.
- R7: `flag_v` is set when the add, subtract or rounding step overflows the 56-bit signed range. In that case the accumulator keeps the wrapped 56-bit value.
- R8: `rd_data` shows bits 47..24 of the selected, scaled accumulator. If the scaled value lies outside the 24-bit fractional range, it shows 0x7FFFFF (positive) or 0x800000 (negative), and `flag_l` is high.
- R9: `rd_scale` 2'b00 and 2'b11 read unscaled. 2'b01 shifts right by one bit (arithmetic), and 2'b10 shifts left by one bit, before the saturation of R8.
- R10: After reset both accumulators and all registered flags are zero, `rd_data` is 0 and `flag_l` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Performs the operation on this edge |
| opcode | input | 2 | Operation select (load, add, subtract, negated load) |
| round_en | input | 1 | Applies convergent rounding to the result |
| acc_sel | input | 1 | Destination accumulator |
| op_a | input | 24 | First signed fractional operand |
| op_b | input | 24 | Second signed fractional operand |
| rd_sel | input | 1 | Accumulator shown on the read port |
| rd_scale | input | 2 | Read-out scaling mode |
| rd_data | output | 24 | Scaled, saturated read-out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Result overflowed 56 bits |
| flag_e | output | 1 | Guard bits in use |
| flag_l | output | 1 | Read-out limited |

## Verification
The bench squares -1.0. A design that sign-extends after the shift, instead of before, would hold a negative accumulator there. It drives exact half-LSB ties above both even and odd upper words, and ties below zero. Rounding half-up would leave the upper word odd, and never clearing bit 24 would fail the negative tie. It accumulates +1.0 more than 255 times to push past the guard bits, where an overflow test on the wrong bit either misses or fires early. At the read port it checks scaling of +0.5 and -0.5, where -1.0 is the single in-range value that a sloppy saturation bound would wrongly limit.

// File: rtl/fracmac_pkg.sv
`timescale 1ns/1ps
package fracmac_pkg;

    typedef enum logic [1:0] {
        OP_MPY = 2'b00,
        OP_MAC = 2'b01,
        OP_MSU = 2'b10,
        OP_NEG = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        SC_NONE = 2'b00,
        SC_DOWN = 2'b01,
        SC_UP   = 2'b10,
        SC_RSVD = 2'b11
    } scale_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic e;
    } ccr_t;

endpackage

// File: rtl/fracmac_mult.sv
`timescale 1ns/1ps
module fracmac_mult #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 56
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [ACC_W-1:0]  prod
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW-1:0] raw;
    logic [ACC_W-1:0]     widened;

    assign raw     = $signed(a) * $signed(b);
    // extend before the fractional shift so +1.0 does not turn negative
    assign widened = {{(ACC_W-PW){raw[PW-1]}}, raw};
    assign prod    = widened << 1;
endmodule

// File: rtl/fracmac_round.sv
`timescale 1ns/1ps
module fracmac_round #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 56
) (
    input  logic [ACC_W-1:0] din,
    input  logic             en,
    output logic [ACC_W-1:0] dout,
    output logic             ovf
);
    localparam logic [ACC_W-1:0]  HALF    = ACC_W'(1) << (DATA_W-1);
    localparam logic [DATA_W-1:0] TIE_PAT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [ACC_W-1:0] bumped;
    logic             tie;

    assign bumped = din + HALF;
    assign tie    = (din[DATA_W-1:0] == TIE_PAT);

    always_comb begin
        dout = din;
        ovf  = 1'b0;
        if (en) begin
            dout = bumped;
            if (tie) begin
                dout[DATA_W] = 1'b0;
            end
            dout[DATA_W-1:0] = '0;
            ovf = ~din[ACC_W-1] & bumped[ACC_W-1];
        end
    end
endmodule

// File: rtl/fracmac_readout.sv
`timescale 1ns/1ps
module fracmac_readout #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 56
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [1:0]        scale,
    output logic [DATA_W-1:0] data,
    output logic              lim
);
    import fracmac_pkg::*;

    localparam int TOPB = 2 * DATA_W - 1;
    localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    logic [ACC_W:0]      scaled;
    logic [ACC_W-TOPB:0] head;
    logic                in_range;

    always_comb begin
        case (scale_e'(scale))
            SC_DOWN: scaled = {acc[ACC_W-1], acc[ACC_W-1], acc[ACC_W-1:1]};
            SC_UP:   scaled = {acc, 1'b0};
            default: scaled = {acc[ACC_W-1], acc};
        endcase
    end

    assign head     = scaled[ACC_W:TOPB];
    assign in_range = (&head) | ~(|head);

    always_comb begin
        if (in_range) begin
            data = scaled[TOPB:DATA_W];
        end else if (scaled[ACC_W]) begin
            data = NEG_FS;
        end else begin
            data = POS_FS;
        end
        lim = ~in_range;
    end
endmodule

// File: rtl/fracmac_unit.sv
`timescale 1ns/1ps
module fracmac_unit #(
    parameter int DATA_W  = 24,
    parameter int GUARD_W = 8,
    parameter int NUM_ACC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 opcode,
    input  logic                       round_en,
    input  logic [$clog2(NUM_ACC)-1:0] acc_sel,
    input  logic [DATA_W-1:0]          op_a,
    input  logic [DATA_W-1:0]          op_b,
    input  logic [$clog2(NUM_ACC)-1:0] rd_sel,
    input  logic [1:0]                 rd_scale,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       flag_n,
    output logic                       flag_z,
    output logic                       flag_v,
    output logic                       flag_e,
    output logic                       flag_l
);
    import fracmac_pkg::*;

    localparam int ACC_W = GUARD_W + 2 * DATA_W;
    localparam int SEL_W = $clog2(NUM_ACC);
    localparam int EXT_LO = 2 * DATA_W - 1;
    localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_q [NUM_ACC];
    logic [ACC_W-1:0] acc_old;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   sum_x;
    logic [ACC_W-1:0] sum_w;
    logic             add_ovf;
    logic [ACC_W-1:0] result;
    logic             rnd_ovf;
    logic             use_acc;
    logic             neg_p;
    mac_op_e          op_e;
    ccr_t             ccr_q;
    ccr_t             ccr_d;

    assign op_e    = mac_op_e'(opcode);
    assign acc_old = acc_q[acc_sel];

    fracmac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) mult_i (
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    always_comb begin
        unique case (op_e)
            OP_MPY: begin use_acc = 1'b0; neg_p = 1'b0; end
            OP_MAC: begin use_acc = 1'b1; neg_p = 1'b0; end
            OP_MSU: begin use_acc = 1'b1; neg_p = 1'b1; end
            OP_NEG: begin use_acc = 1'b0; neg_p = 1'b1; end
        endcase
    end

    assign addend  = neg_p ? (~prod + ACC_W'(1)) : prod;
    assign base    = use_acc ? acc_old : '0;
    assign sum_x   = {base[ACC_W-1], base} + {addend[ACC_W-1], addend};
    assign sum_w   = sum_x[ACC_W-1:0];
    assign add_ovf = sum_x[ACC_W] ^ sum_x[ACC_W-1];

    fracmac_round #(.DATA_W(DATA_W), .ACC_W(ACC_W)) round_i (
        .din  (sum_w),
        .en   (round_en),
        .dout (result),
        .ovf  (rnd_ovf)
    );

    always_comb begin
        ccr_d.n = result[ACC_W-1];
        ccr_d.z = (result == '0);
        ccr_d.v = add_ovf | rnd_ovf;
        ccr_d.e = ~((&result[ACC_W-1:EXT_LO]) | ~(|result[ACC_W-1:EXT_LO]));
    end

    generate
        for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc_q[g] <= '0;
                end else if (in_valid && (acc_sel == SEL_W'(g))) begin
                    acc_q[g] <= result;
                end
            end

            // R3, R4
            acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(in_valid && (acc_sel == SEL_W'(g))) |=> $stable(acc_q[g]));

            // R5
            round_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && round_en && (acc_sel == SEL_W'(g)))
                |=> (acc_q[g][DATA_W-1:0] == '0));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccr_q <= '0;
        end else if (in_valid) begin
            ccr_q <= ccr_d;
        end
    end

    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_e = ccr_q.e;

    fracmac_readout #(.DATA_W(DATA_W), .ACC_W(ACC_W)) readout_i (
        .acc   (acc_q[rd_sel]),
        .scale (rd_scale),
        .data  (rd_data),
        .lim   (flag_l)
    );

    // R6
    zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);

    // R7
    mpy_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 2'b00)) |=> !flag_v);

    // R8
    limit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_l |-> ((rd_data == POS_FS) || (rd_data == NEG_FS)));
endmodule

// File: tb/fracmac_unit_tb.sv
`timescale 1ns/1ps
module fracmac_unit_tb_top;

    localparam longint MAXA = 64'sd36028797018963967;
    localparam longint MINA = -64'sd36028797018963968;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic        round_en = 1'b0;
    logic        acc_sel = 1'b0;
    logic [23:0] op_a = '0;
    logic [23:0] op_b = '0;
    logic        rd_sel = 1'b0;
    logic [1:0]  rd_scale = 2'b00;
    logic [23:0] rd_data;
    logic        flag_n, flag_z, flag_v, flag_e, flag_l;

    always #5 clk = ~clk;

    fracmac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .round_en(round_en), .acc_sel(acc_sel), .op_a(op_a), .op_b(op_b),
        .rd_sel(rd_sel), .rd_scale(rd_scale), .rd_data(rd_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_e(flag_e),
        .flag_l(flag_l)
    );

    typedef struct {
        string       tag;
        logic [55:0] acc;
        logic        v;
    } exp_t;

    exp_t        sb_q[$];
    logic [55:0] macc [2];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    function automatic longint sx(input logic [55:0] v);
        longint t;
        t = longint'($signed(v));
        return t;
    endfunction

    function automatic void ref_rd(input logic [55:0] v, input logic [1:0] sc,
                                   output logic [23:0] d, output logic l);
        longint x, hi;
        x = sx(v);
        if (sc == 2'b01) x = x >>> 1;
        else if (sc == 2'b10) x = x * 2;
        hi = x >>> 24;
        l = 1'b0;
        if (hi > 64'sd8388607) begin
            d = 24'h7FFFFF; l = 1'b1;
        end else if (hi < -64'sd8388608) begin
            d = 24'h800000; l = 1'b1;
        end else begin
            d = hi[23:0];
        end
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic s, input logic [1:0] op, input logic [23:0] a,
                         input logic [23:0] b, input logic r, input string tag);
        longint base, p, sm, rr;
        logic [55:0] w;
        logic ov, tie;
        exp_t it;
        @(negedge clk);
        base = (op == 2'b01 || op == 2'b10) ? sx(macc[s]) : 64'sd0;
        p  = longint'($signed(a)) * longint'($signed(b)) * 2;
        sm = op[1] ? (base - p) : (base + p);
        ov = (sm > MAXA) || (sm < MINA);
        w  = sm[55:0];
        if (r) begin
            rr  = sx(w) + 64'sd8388608;
            if (rr > MAXA) ov = 1'b1;
            tie = (w[23:0] == 24'h800000);
            w   = rr[55:0];
            if (tie) w[24] = 1'b0;
            w[23:0] = '0;
        end
        macc[s] = w;
        it.tag = tag; it.acc = w; it.v = ov;
        sb_q.push_back(it);
        in_valid = 1'b1; opcode = op; round_en = r; acc_sel = s;
        op_a = a; op_b = b; rd_sel = s; rd_scale = 2'b00;
    endtask

    task automatic check_rd(input logic s, input logic [1:0] sc, input string tag);
        logic [23:0] d;
        logic l;
        @(negedge clk);
        in_valid = 1'b0; rd_sel = s; rd_scale = sc;
        #1;
        ref_rd(macc[s], sc, d, l);
        chk(tag, {39'd0, rd_data, flag_l}, {39'd0, d, l});
    endtask

    // monitor: pops one expected item per accepted operation
    initial begin
        forever begin
            @(posedge clk);
            if (in_valid) begin
                exp_t it;
                logic [23:0] d;
                logic l, e;
                #2;
                if (sb_q.size() == 0) begin
                    chk("R3 unexpected result", 64'd1, 64'd0);
                end else begin
                    it = sb_q.pop_front();
                    ref_rd(it.acc, 2'b00, d, l);
                    e = !((&it.acc[55:47]) || !(|it.acc[55:47]));
                    chk(it.tag,
                        {35'd0, rd_data, flag_n, flag_z, flag_v, flag_e, flag_l},
                        {35'd0, d, it.acc[55], (it.acc == 56'd0), it.v, e, l});
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        macc[0] = '0; macc[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 reset state
        chk("R10 reset outputs", {58'd0, rd_data[0], flag_n, flag_z, flag_v, flag_e, flag_l}
            | {40'd0, rd_data}, 64'd0);
        check_rd(1'b1, 2'b00, "R10 acc1 reset");

        // R1 products
        do_op(1'b0, 2'b00, 24'h400000, 24'h400000, 1'b0, "R1 half times half");
        do_op(1'b1, 2'b00, 24'h800000, 24'h800000, 1'b0, "R1 minus one squared");
        do_op(1'b0, 2'b00, 24'h7FFFFF, 24'h800000, 1'b0, "R1 max times min");
        do_op(1'b0, 2'b00, 24'h400000, 24'h400000, 1'b0, "R1 reload quarter");
        // R4 other accumulator untouched
        check_rd(1'b1, 2'b00, "R4 acc1 kept");

        // R2 opcodes
        do_op(1'b0, 2'b01, 24'h200000, 24'h400000, 1'b0, "R2 MAC add");
        do_op(1'b0, 2'b10, 24'h600000, 24'h400000, 1'b0, "R2 MSU subtract");
        do_op(1'b0, 2'b11, 24'h123456, 24'hFEDCBA, 1'b0, "R2 negated load");
        do_op(1'b0, 2'b10, 24'h000000, 24'h7FFFFF, 1'b0, "R6 zero product");

        // R3 in_valid low ignored
        @(negedge clk);
        in_valid = 1'b0; opcode = 2'b00; op_a = 24'h7FFFFF; op_b = 24'h7FFFFF; acc_sel = 1'b0;
        repeat (2) @(negedge clk);
        check_rd(1'b0, 2'b00, "R3 idle ignored");

        // R5 convergent rounding
        do_op(1'b0, 2'b00, 24'h000001, 24'h400000, 1'b1, "R5 tie even stays");
        do_op(1'b0, 2'b00, 24'h000002, 24'h400000, 1'b0, "R5 setup odd upper");
        do_op(1'b0, 2'b01, 24'h000001, 24'h400000, 1'b1, "R5 tie odd goes up");
        do_op(1'b0, 2'b00, 24'h000001, 24'h400001, 1'b1, "R5 above half up");
        do_op(1'b0, 2'b00, 24'h000001, 24'h3FFFFF, 1'b1, "R5 below half down");
        do_op(1'b0, 2'b11, 24'h000001, 24'h400000, 1'b1, "R5 negative tie");
        do_op(1'b0, 2'b11, 24'h000003, 24'h400000, 1'b1, "R5 negative odd tie");

        // R9 scaling of +0.5 and -0.5
        do_op(1'b0, 2'b00, 24'h400000, 24'h400000, 1'b0, "R9 quarter");
        do_op(1'b0, 2'b01, 24'h400000, 24'h400000, 1'b0, "R9 half");
        check_rd(1'b0, 2'b00, "R9 none half");
        check_rd(1'b0, 2'b01, "R9 down half");
        check_rd(1'b0, 2'b10, "R9 up half saturates R8");
        check_rd(1'b0, 2'b11, "R9 reserved as none");
        do_op(1'b0, 2'b11, 24'h400000, 24'h400000, 1'b0, "R9 minus quarter");
        do_op(1'b0, 2'b10, 24'h400000, 24'h400000, 1'b0, "R9 minus half");
        check_rd(1'b0, 2'b10, "R9 up minus half no limit R8");
        check_rd(1'b0, 2'b01, "R9 down minus half");

        // R7 overflow by repeated accumulation of +1.0 into acc1
        for (int k = 0; k < 258; k++) begin
            do_op(1'b1, 2'b01, 24'h800000, 24'h800000, 1'b0, "R7 accumulate overflow");
        end
        do_op(1'b1, 2'b10, 24'h7FFFFF, 24'h7FFFFF, 1'b0, "R7 subtract after wrap");
        check_rd(1'b1, 2'b00, "R8 negative limit");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule